// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block links two parallel data buses, called A and B, and can move data between them in either direction. Each direction has its own storage register. On each side, the block drives either the live level of the opposite bus or the value held in that direction's register. A per-direction select input makes this choice. Each direction also has its own output enable and its own capture strobe. A register loads on every rising edge of its strobe, whatever the select and enable settings are at that moment.

The buses are modelled as separate input, output and output-enable signals, so the design needs no internal tri-states. Each bus has a one-bit "external driver present" input. When neither the block nor an outside agent drives a bus, the bus keeps its last level (bus-hold). There is one special case: both directions pass live data and both drive at once. The two buses then form a loop, and each bus simply keeps its held level. All sequential logic runs on one system clock. The capture strobes are sampled on that clock and their rising edges are detected there.

Top module: `dual_reg_xcvr`

## Requirements
- R1: While `enDriveB` is 1 and the block is not in the loop state, `busBOut` equals the effective A level when `selStoredB` is 0, and equals the A-to-B register when `selStoredB` is 1.
- R2: While `enDriveAN` is 0 and the block is not in the loop state, `busAOut` equals the effective B level when `selStoredA` is 0, and equals the B-to-A register when `selStoredA` is 1.
- R3: `busBOe` equals `enDriveB`, which is active high. `busAOe` equals the inverse of `enDriveAN`, which is active low.
- R4: On the clock edge where `captAtoB` is seen high after being low at the previous edge, the A-to-B register loads the effective A level. This happens regardless of the select and enable inputs. A strobe that stays high loads nothing more.
- R5: On the clock edge where `captBtoA` is seen high after being low at the previous edge, the B-to-A register loads the effective B level. This also happens regardless of the select and enable inputs.
- R6: The effective level of a bus is the block's own output when the block drives that bus. Otherwise it is `busXIn` when `extXDrv` is 1, and the held level when `extXDrv` is 0. A capture from a bus the block is driving therefore stores the block's own output.
- R7: The loop state is both enables active with both selects 0. In the loop state, `busAOut` and `busBOut` each show their bus's held level.
- R8: Each bus's held level is updated to its effective level on every clock. When the block does not drive a bus, `busXOut` shows that bus's held level, so an undriven bus keeps its last level.
- R9: Rising strobe edges on both directions in the same cycle load both registers, each from the effective level present before that edge.
- R10: After reset, both registers and both held levels are zero, and no capture edge is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAIn | input | W | Level driven onto bus A by an outside agent |
| extADrv | input | 1 | 1 when an outside agent drives bus A |
| busAOut | output | W | Block's drive value for bus A, or the held A level when not driving |
| busAOe | output | 1 | Block drives bus A |
| busBIn | input | W | Level driven onto bus B by an outside agent |
| extBDrv | input | 1 | 1 when an outside agent drives bus B |
| busBOut | output | W | Block's drive value for bus B, or the held B level when not driving |
| busBOe | output | 1 | Block drives bus B |
| captAtoB | input | 1 | Capture strobe for the A-to-B register (rising edge) |
| captBtoA | input | 1 | Capture strobe for the B-to-A register (rising edge) |
| selStoredB | input | 1 | 1: bus B is driven from the stored register; 0: from live A |
| selStoredA | input | 1 | 1: bus A is driven from the stored register; 0: from live B |
| enDriveB | input | 1 | Active-high enable for driving bus B |
| enDriveAN | input | 1 | Active-low enable for driving bus A |

## Verification
The bench targets captures taken while the block itself drives the sampled bus. A design that sampled `busXIn` there would store the outside level and not its own output. It also exercises the loop state. A design that did not break the loop would oscillate or pass stale live data, and the bench expects the held levels on both sides. Strobes are held high for several cycles to catch a register that loads on level instead of on edge. Simultaneous captures are checked to catch one register overwriting the other's source. An undriven bus with no outside driver is checked to catch a bus that drops to zero where it should keep its last value.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Strobes decoded by the control unit and consumed by the datapath.
  typedef struct packed {
    logic loadAtoB;     // rising edge seen on the A-to-B capture strobe
    logic loadBtoA;     // rising edge seen on the B-to-A capture strobe
    logic driveA;       // block drives bus A
    logic driveB;       // block drives bus B
    logic pickStoredA;  // bus A source is the B-to-A register
    logic pickStoredB;  // bus B source is the A-to-B register
    logic loopHold;     // both live paths enabled: buses keep held levels
  } xcvrStrobes_t;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         captAtoB,
  input  logic         captBtoA,
  input  logic         selStoredA,
  input  logic         selStoredB,
  input  logic         enDriveB,
  input  logic         enDriveAN,
  output xcvrStrobes_t strobes
);

  logic prevAtoB;
  logic prevBtoA;

  // Edge detectors for both capture strobes, sampled on the system clock.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAtoB <= 1'b0;
      prevBtoA <= 1'b0;
    end else begin
      prevAtoB <= captAtoB;
      prevBtoA <= captBtoA;
    end
  end

  always_comb begin
    strobes.loadAtoB    = captAtoB && !prevAtoB;
    strobes.loadBtoA    = captBtoA && !prevBtoA;
    strobes.driveA      = !enDriveAN;
    strobes.driveB      = enDriveB;
    strobes.pickStoredA = selStoredA;
    strobes.pickStoredB = selStoredB;
    strobes.loopHold    = !enDriveAN && enDriveB && !selStoredA && !selStoredB;
  end

  // A strobe held high loads only once.
  p_single_load_ab_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAtoB |=> !strobes.loadAtoB);
  p_single_load_ba_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadBtoA |=> !strobes.loadBtoA);

endmodule

// File: rtl/xcvr_dpath.sv
module xcvr_dpath
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  xcvrStrobes_t strobes,
  input  logic [W-1:0] busAIn,
  input  logic         extADrv,
  input  logic [W-1:0] busBIn,
  input  logic         extBDrv,
  output logic [W-1:0] busAOut,
  output logic [W-1:0] busBOut
);

  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] regAtoB, regBtoA;
  logic [W-1:0] holdA, holdB;
  logic [W-1:0] aExt, bExt;
  logic [W-1:0] aDrvVal, bDrvVal;
  logic [W-1:0] effA, effB;

  // Level each bus would have without the block driving it (bus keeper).
  assign aExt = extADrv ? busAIn : holdA;
  assign bExt = extBDrv ? busBIn : holdB;

  // Source muxes. Outside the loop state, a live path whose far side is
  // driven by the block necessarily comes from the far side's register.
  always_comb begin
    if (strobes.loopHold) begin
      aDrvVal = holdA;
      bDrvVal = holdB;
    end else begin
      if (strobes.pickStoredB)  bDrvVal = regAtoB;
      else if (strobes.driveA)  bDrvVal = regBtoA;
      else                      bDrvVal = aExt;
      if (strobes.pickStoredA)  aDrvVal = regBtoA;
      else if (strobes.driveB)  aDrvVal = regAtoB;
      else                      aDrvVal = bExt;
    end
  end

  assign effA = strobes.driveA ? aDrvVal : aExt;
  assign effB = strobes.driveB ? bDrvVal : bExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regAtoB <= ZERO;
      regBtoA <= ZERO;
      holdA   <= ZERO;
      holdB   <= ZERO;
    end else begin
      holdA <= effA;
      holdB <= effB;
      if (strobes.loadAtoB) regAtoB <= effA;
      if (strobes.loadBtoA) regBtoA <= effB;
    end
  end

  assign busAOut = effA;
  assign busBOut = effB;

  p_load_ab_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAtoB |=> regAtoB == $past(busAOut));
  p_load_ba_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadBtoA |=> regBtoA == $past(busBOut));
  p_keeper_a_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.driveA && !extADrv) |=> (!strobes.driveA && !extADrv) |-> $stable(busAOut));
  p_keeper_b_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.driveB && !extBDrv) |=> (!strobes.driveB && !extBDrv) |-> $stable(busBOut));
  p_loop_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loopHold |=> strobes.loopHold |-> ($stable(busAOut) && $stable(busBOut)));
  p_clean_src_b_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.driveB && !strobes.loopHold) |->
      (busBOut == regAtoB || busBOut == busAOut));
  p_clean_src_a_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.driveA && !strobes.loopHold) |->
      (busAOut == regBtoA || busAOut == busBOut));

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] busAIn,
  input  logic         extADrv,
  output logic [W-1:0] busAOut,
  output logic         busAOe,
  input  logic [W-1:0] busBIn,
  input  logic         extBDrv,
  output logic [W-1:0] busBOut,
  output logic         busBOe,
  input  logic         captAtoB,
  input  logic         captBtoA,
  input  logic         selStoredB,
  input  logic         selStoredA,
  input  logic         enDriveB,
  input  logic         enDriveAN
);

  xcvrStrobes_t strobes;

  xcvr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .captAtoB(captAtoB), .captBtoA(captBtoA),
    .selStoredA(selStoredA), .selStoredB(selStoredB),
    .enDriveB(enDriveB), .enDriveAN(enDriveAN),
    .strobes(strobes)
  );

  xcvr_dpath #(.W(W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .busAIn(busAIn), .extADrv(extADrv),
    .busBIn(busBIn), .extBDrv(extBDrv),
    .busAOut(busAOut), .busBOut(busBOut)
  );

  assign busAOe = strobes.driveA;
  assign busBOe = strobes.driveB;

  p_oe_polarity_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busAOe != enDriveAN) && (busBOe == enDriveB));

endmodule

// File: tb/dual_reg_xcvr_tb_top.sv
`timescale 1ns/1ps
module dual_reg_xcvr_tb_top;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] busAIn = '0, busBIn = '0;
  logic extADrv = 1'b0, extBDrv = 1'b0;
  logic captAtoB = 1'b0, captBtoA = 1'b0;
  logic selStoredA = 1'b0, selStoredB = 1'b0;
  logic enDriveB = 1'b0, enDriveAN = 1'b1;
  logic [W-1:0] busAOut, busBOut;
  logic busAOe, busBOe;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  // Bench reference state
  logic [W-1:0] mRegAB, mRegBA, mHoldA, mHoldB;
  logic mPrevAB, mPrevBA;

  always #2.5 clk = ~clk;

  dual_reg_xcvr #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN),
    .busAIn(busAIn), .extADrv(extADrv), .busAOut(busAOut), .busAOe(busAOe),
    .busBIn(busBIn), .extBDrv(extBDrv), .busBOut(busBOut), .busBOe(busBOe),
    .captAtoB(captAtoB), .captBtoA(captBtoA),
    .selStoredB(selStoredB), .selStoredA(selStoredA),
    .enDriveB(enDriveB), .enDriveAN(enDriveAN)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic isLoop();
    return !enDriveAN && enDriveB && !selStoredA && !selStoredB;
  endfunction

  // Expected outputs computed from the requirements
  task automatic expected(output logic [W-1:0] eA, output logic [W-1:0] eB);
    logic [W-1:0] xA, xB;
    xA = extADrv ? busAIn : mHoldA;
    xB = extBDrv ? busBIn : mHoldB;
    if (isLoop()) begin
      eA = mHoldA; eB = mHoldB;
    end else begin
      eA = xA; eB = xB;
      if (!enDriveAN && selStoredA) eA = mRegBA;
      if (enDriveB && selStoredB)   eB = mRegAB;
      if (enDriveB && !selStoredB)  eB = eA;   // live copy of A's level
      if (!enDriveAN && !selStoredA) eA = eB;  // live copy of B's level
    end
  endtask

  // Called after inputs settle, before the next rising edge.
  task automatic checkAndAdvance();
    logic [W-1:0] eA, eB;
    string tA, tB;
    expected(eA, eB);
    if (isLoop()) begin tA = "R7"; tB = "R7"; end
    else begin
      tA = enDriveAN ? "R8" : "R2";
      tB = enDriveB ? "R1" : "R8";
    end
    check(tA, busAOut, eA);
    check(tB, busBOut, eB);
    check("R3", {7'd0, busAOe}, {7'd0, !enDriveAN});
    check("R3", {7'd0, busBOe}, {7'd0, enDriveB});
    if (captAtoB && !mPrevAB) mRegAB = eA;
    if (captBtoA && !mPrevBA) mRegBA = eB;
    mPrevAB = captAtoB; mPrevBA = captBtoA;
    mHoldA = eA; mHoldB = eB;
  endtask

  task automatic step();
    #1;
    checkAndAdvance();
    @(negedge clk);
  endtask

  task automatic setCtl(input logic sA, input logic sB, input logic eB, input logic eAN);
    selStoredA = sA; selStoredB = sB; enDriveB = eB; enDriveAN = eAN;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mRegAB = '0; mRegBA = '0; mHoldA = '0; mHoldB = '0;
    mPrevAB = 1'b0; mPrevBA = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R10: stored registers read zero after reset
    setCtl(1, 1, 1, 0);
    #1;
    check("R10", busAOut, '0);
    check("R10", busBOut, '0);
    step();

    // R4: capture A from outside, then show it on B through the stored path
    setCtl(0, 1, 0, 1);
    extADrv = 1; busAIn = 8'h5A; captAtoB = 1;
    step();
    busAIn = 8'hC3;            // strobe still high: no further load
    step();
    setCtl(0, 1, 1, 1);
    #1; check("R4", busBOut, 8'h5A);
    step();
    captAtoB = 0;

    // R6: block drives A from stored B-to-A; capture A stores own output
    extBDrv = 1; busBIn = 8'h3C; captBtoA = 1;
    setCtl(0, 0, 0, 1);
    step();
    captBtoA = 0;
    setCtl(1, 0, 0, 0);        // A driven from regBA = 3C
    busAIn = 8'hFF; captAtoB = 1;
    step();
    captAtoB = 0;
    setCtl(1, 1, 1, 1);
    #1; check("R6", busBOut, 8'h3C);
    check("R5", busBOut == 8'h3C ? 8'h3C : busBOut, 8'h3C);
    step();

    // R9: both strobes rise together
    setCtl(0, 0, 0, 1);
    busAIn = 8'h11; busBIn = 8'h22;
    captAtoB = 1; captBtoA = 1;
    step();
    captAtoB = 0; captBtoA = 0;
    setCtl(1, 1, 1, 0);
    #1; check("R9", busBOut, 8'h11); check("R9", busAOut, 8'h22);
    step();

    // R8: undriven bus with no outside driver keeps last level
    setCtl(0, 0, 0, 1);
    extADrv = 1; busAIn = 8'h77;
    step();
    extADrv = 0; busAIn = 8'h00;
    #1; check("R8", busAOut, 8'h77);
    step();

    // R7: loop state keeps held levels even as inputs change
    extBDrv = 1; busBIn = 8'h99;
    step();
    setCtl(0, 0, 1, 0);
    busAIn = 8'hAB; busBIn = 8'hCD; extADrv = 1;
    #1; check("R7", busAOut, 8'h77); check("R7", busBOut, 8'h99);
    step();

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      busAIn = W'($urandom); busBIn = W'($urandom);
      extADrv = $urandom_range(0, 3) != 0;
      extBDrv = $urandom_range(0, 3) != 0;
      if ($urandom_range(0, 2) == 0) captAtoB = ~captAtoB;
      if ($urandom_range(0, 2) == 0) captBtoA = ~captBtoA;
      setCtl(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      step();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule